// File: doc/BRIEF.md
# Asynchronous Static RAM Access Sequencer

This block lets synchronous logic read and write a 32768-byte asynchronous static RAM. The RAM has no clock and no refresh. The user side issues a one-cycle request that carries an address, a write flag and write data. The block answers with a one-cycle completion pulse and, for reads, the byte it captured. While an access is in flight the block reports itself busy and drops any further request.

On the memory side the block drives active-low select, write strobe and output enable, a 15-bit address, and an 8-bit data bus split into outbound data, inbound data and a drive enable. Every phase length is derived at elaboration from nanosecond timing parameters and the clock period. Each phase takes the ceiling of the time divided by the period, and never less than one clock.

Writes are shaped around the rule that a write lasts only while select and write strobe are both low. Output enable stays high for the whole write. The block turns on its own data drivers only once the strobe is already low. After each read, turnaround cycles let the memory's output drivers switch off before the block can drive the bus again.

Top module: `asram_ctrl`

## Requirements
- R1: During and right after reset, select, write strobe and output enable are high (inactive), the drive enable is 0, and done and busy are 0.
- R2: A read request accepted while idle lowers select and output enable with the request address. It returns the byte the memory presents, with done, RD_CYC clock edges after the request edge. RD_CYC is the largest of the cycle counts for cycle time, address access, select access and output-enable access (2 at the default 10 ns clock).
- R3: A write request accepted while idle lowers select first. After the setup phase it holds the write strobe low for exactly WP_CYC clocks (2 by default) and stores the request data at the addressed byte. Done follows setup + strobe + recovery edges after the request edge (4 by default).
- R4: The write strobe is low only while select is low and output enable is high.
- R5: The drive enable rises only in a clock where the write strobe was already low in the clock before. It is still high in the clock in which the strobe rises, and it is 0 one clock later. It is never high while output enable and select are both low.
- R6: Done is high for exactly one clock per accepted request.
- R7: A request made while busy is ignored: it produces no done and leaves memory contents unchanged.
- R8: After a read, busy stays high for OHZ_CYC clocks counted from the done clock (1 by default), with select high and the drive enable 0. After a write, busy is already 0 in the done clock. Whenever busy is 0, select is high and the drive enable is 0.
- R9: The memory address does not change while select remains low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req | input | 1 | One-cycle access request, taken only when idle |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | 15 | Byte address |
| req_wdata | input | 8 | Write data |
| done | output | 1 | One-cycle completion pulse |
| busy | output | 1 | Access or turnaround in progress |
| rdata | output | 8 | Byte captured by the last read |
| mem_cs_n | output | 1 | Memory select, active low |
| mem_we_n | output | 1 | Memory write strobe, active low |
| mem_oe_n | output | 1 | Memory output enable, active low |
| mem_addr | output | 15 | Memory address |
| mem_dq_out | output | 8 | Data toward the memory |
| mem_dq_in | input | 8 | Data from the memory |
| mem_dq_oe | output | 1 | Drive enable for mem_dq_out |

## Verification
A request is driven at the falling edge before its request edge. Done is then sampled at each later falling edge: it must first appear RD_CYC+1 falling edges later for a read and setup+strobe+recovery+1 for a write, and the clock after that it must be gone. Busy after a read must fall exactly OHZ_CYC falling edges after done, and after a write it must already be low in the done clock. A falling-edge memory model counts the strobe-low clocks, checks drive-enable timing against the strobe and stores the byte when the strobe rises. Stored bytes are compared later by reads against a bench copy.

// File: rtl/asram_pkg.sv
// Shared types and elaboration-time helpers for the SRAM access sequencer.
// Assumes all timing values are non-negative integers in nanoseconds.
package asram_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RACC,
        ST_TURN,
        ST_WSET,
        ST_WPUL,
        ST_WREC
    } seq_state_t;

    // Clocks needed to cover t_ns at per_ns per clock, never below one.
    function automatic int unsigned ns_to_cyc(int unsigned t_ns, int unsigned per_ns);
        int unsigned c;
        c = (t_ns + per_ns - 1) / per_ns;
        return (c == 0) ? 1 : c;
    endfunction

    function automatic int unsigned umax(int unsigned a, int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/asram_timer.sv
// Phase down-counter. Loading N-1 makes the zero flag rise after N-1 more
// clocks, so a phase entered with a load lasts exactly N clocks.
// Assumes load_val fits CNT_W bits.
module asram_timer #(
    parameter int CNT_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             zero
);
    logic [CNT_W-1:0] cnt;

    // Load on phase entry, otherwise count down and stop at zero.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (load)
            cnt <= load_val;
        else if (cnt != '0)
            cnt <= cnt - 1'b1;
    end

    assign zero = (cnt == '0);
endmodule

// File: rtl/asram_datapath.sv
// Address, write-data and read-capture registers. The address and outbound
// data are latched when a request is taken and held until the next one.
// Inbound data is captured on the edge that closes the read access phase.
module asram_datapath #(
    parameter int ADDR_W = 15,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              accept,
    input  logic              capture,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [DATA_W-1:0] mem_dq_in,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_dq_out,
    output logic [DATA_W-1:0] rdata
);
    // Latch the request address and data when a request is taken.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mem_addr   <= '0;
            mem_dq_out <= '0;
        end else if (accept) begin
            mem_addr   <= req_addr;
            mem_dq_out <= req_wdata;
        end
    end

    // Capture the memory byte at the end of a read access.
    always_ff @(posedge clk) begin
        if (!rst_n)
            rdata <= '0;
        else if (capture)
            rdata <= mem_dq_in;
    end
endmodule

// File: rtl/asram_seq.sv
// Access sequencer: walks read and write phases and drives the registered
// memory strobes. Phase lengths arrive as clock counts of at least one.
// Assumes WP_CYC >= 2 so the data drivers overlap the strobe by a clock.
module asram_seq
    import asram_pkg::*;
#(
    parameter int          CNT_W   = 2,
    parameter int unsigned RD_CYC  = 2,
    parameter int unsigned AS_CYC  = 1,
    parameter int unsigned WP_CYC  = 2,
    parameter int unsigned WR_CYC  = 1,
    parameter int unsigned OHZ_CYC = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req,
    input  logic             req_we,
    input  logic             tmr_zero,
    output logic             tmr_load,
    output logic [CNT_W-1:0] tmr_val,
    output logic             accept,
    output logic             capture,
    output logic             busy,
    output logic             done,
    output logic             mem_cs_n,
    output logic             mem_we_n,
    output logic             mem_oe_n,
    output logic             mem_dq_oe
);
    localparam logic [CNT_W-1:0] RD_LD  = CNT_W'(RD_CYC - 1);
    localparam logic [CNT_W-1:0] AS_LD  = CNT_W'(AS_CYC - 1);
    localparam logic [CNT_W-1:0] WP_LD  = CNT_W'(WP_CYC - 1);
    localparam logic [CNT_W-1:0] WR_LD  = CNT_W'(WR_CYC - 1);
    localparam logic [CNT_W-1:0] OHZ_LD = CNT_W'(OHZ_CYC - 1);

    seq_state_t state;

    // Decide timer loads, request acceptance and read capture for this clock.
    always_comb begin
        accept   = 1'b0;
        capture  = 1'b0;
        tmr_load = 1'b0;
        tmr_val  = '0;
        unique case (state)
            ST_IDLE: if (req) begin
                accept   = 1'b1;
                tmr_load = 1'b1;
                tmr_val  = req_we ? AS_LD : RD_LD;
            end
            ST_RACC: if (tmr_zero) begin
                capture  = 1'b1;
                tmr_load = 1'b1;
                tmr_val  = OHZ_LD;
            end
            ST_WSET: if (tmr_zero) begin
                tmr_load = 1'b1;
                tmr_val  = WP_LD;
            end
            ST_WPUL: if (tmr_zero) begin
                tmr_load = 1'b1;
                tmr_val  = WR_LD;
            end
            default: ;
        endcase
    end

    // Advance the phase and update the registered memory strobes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            mem_cs_n  <= 1'b1;
            mem_we_n  <= 1'b1;
            mem_oe_n  <= 1'b1;
            mem_dq_oe <= 1'b0;
            done      <= 1'b0;
        end else begin
            done <= 1'b0;
            unique case (state)
                ST_IDLE: if (req) begin
                    mem_cs_n <= 1'b0;
                    if (req_we) begin
                        state <= ST_WSET;
                    end else begin
                        mem_oe_n <= 1'b0;
                        state    <= ST_RACC;
                    end
                end
                ST_RACC: if (tmr_zero) begin
                    mem_cs_n <= 1'b1;
                    mem_oe_n <= 1'b1;
                    done     <= 1'b1;
                    state    <= ST_TURN;
                end
                ST_TURN: if (tmr_zero) begin
                    state <= ST_IDLE;
                end
                ST_WSET: if (tmr_zero) begin
                    mem_we_n <= 1'b0;
                    state    <= ST_WPUL;
                end
                ST_WPUL: begin
                    mem_dq_oe <= 1'b1;
                    if (tmr_zero) begin
                        mem_we_n <= 1'b1;
                        state    <= ST_WREC;
                    end
                end
                ST_WREC: if (tmr_zero) begin
                    mem_dq_oe <= 1'b0;
                    mem_cs_n  <= 1'b1;
                    done      <= 1'b1;
                    state     <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign busy = (state != ST_IDLE);
endmodule

// File: rtl/asram_ctrl.sv
// Top of the SRAM access sequencer. Converts nanosecond timing parameters
// into phase clock counts and wires the sequencer, timer and datapath.
// Assumes one access at a time and a memory with output enable ignored
// during writes.
module asram_ctrl
    import asram_pkg::*;
#(
    parameter int ADDR_W    = 15,
    parameter int DATA_W    = 8,
    parameter int CLK_NS    = 10,
    parameter int T_RC_NS   = 15,
    parameter int T_AA_NS   = 15,
    parameter int T_ACS_NS  = 15,
    parameter int T_OE_NS   = 8,
    parameter int T_WP_NS   = 12,
    parameter int T_AW_NS   = 12,
    parameter int T_AS_NS   = 0,
    parameter int T_WR_NS   = 0,
    parameter int T_DW_NS   = 8,
    parameter int T_OHZ_NS  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  logic              req_we,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              done,
    output logic              busy,
    output logic [DATA_W-1:0] rdata,
    output logic              mem_cs_n,
    output logic              mem_we_n,
    output logic              mem_oe_n,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_dq_out,
    input  logic [DATA_W-1:0] mem_dq_in,
    output logic              mem_dq_oe
);
    localparam int unsigned RD_CYC = umax(umax(ns_to_cyc(T_RC_NS, CLK_NS), ns_to_cyc(T_AA_NS, CLK_NS)),
                                          umax(ns_to_cyc(T_ACS_NS, CLK_NS), ns_to_cyc(T_OE_NS, CLK_NS)));
    localparam int unsigned AS_CYC  = ns_to_cyc(T_AS_NS, CLK_NS);
    localparam int unsigned AW_CYC  = ns_to_cyc(T_AW_NS, CLK_NS);
    localparam int unsigned AW_REM  = (AW_CYC > AS_CYC) ? AW_CYC - AS_CYC : 1;
    localparam int unsigned WP_CYC  = umax(umax(ns_to_cyc(T_WP_NS, CLK_NS), ns_to_cyc(T_DW_NS, CLK_NS) + 1),
                                           AW_REM);
    localparam int unsigned WR_CYC  = ns_to_cyc(T_WR_NS, CLK_NS);
    localparam int unsigned OHZ_CYC = ns_to_cyc(T_OHZ_NS, CLK_NS);
    localparam int unsigned MAX_CYC = umax(umax(RD_CYC, AS_CYC), umax(umax(WP_CYC, WR_CYC), OHZ_CYC));
    localparam int          CNT_W   = (MAX_CYC > 1) ? $clog2(MAX_CYC) : 1;

    logic             tmr_load;
    logic [CNT_W-1:0] tmr_val;
    logic             tmr_zero;
    logic             accept;
    logic             capture;

    asram_seq #(
        .CNT_W   (CNT_W),
        .RD_CYC  (RD_CYC),
        .AS_CYC  (AS_CYC),
        .WP_CYC  (WP_CYC),
        .WR_CYC  (WR_CYC),
        .OHZ_CYC (OHZ_CYC)
    ) i_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .req       (req),
        .req_we    (req_we),
        .tmr_zero  (tmr_zero),
        .tmr_load  (tmr_load),
        .tmr_val   (tmr_val),
        .accept    (accept),
        .capture   (capture),
        .busy      (busy),
        .done      (done),
        .mem_cs_n  (mem_cs_n),
        .mem_we_n  (mem_we_n),
        .mem_oe_n  (mem_oe_n),
        .mem_dq_oe (mem_dq_oe)
    );

    asram_timer #(.CNT_W(CNT_W)) i_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .zero     (tmr_zero)
    );

    asram_datapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_dp (
        .clk        (clk),
        .rst_n      (rst_n),
        .accept     (accept),
        .capture    (capture),
        .req_addr   (req_addr),
        .req_wdata  (req_wdata),
        .mem_dq_in  (mem_dq_in),
        .mem_addr   (mem_addr),
        .mem_dq_out (mem_dq_out),
        .rdata      (rdata)
    );
endmodule

// File: rtl/asram_ctrl_chk.sv
// Protocol checker for the SRAM access sequencer, bound to its ports.
// Observes only the top-level ports.
module asram_ctrl_chk #(
    parameter int ADDR_W = 15,
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              done,
    input logic              busy,
    input logic              mem_cs_n,
    input logic              mem_we_n,
    input logic              mem_oe_n,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              mem_dq_oe
);
    // R4
    wr_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we_n |-> (!mem_cs_n && mem_oe_n));

    // R5
    no_contention_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_dq_oe |-> (mem_oe_n && !mem_cs_n));

    // R5
    drive_after_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_dq_oe) |-> (!mem_we_n && $past(!mem_we_n)));

    // R5
    drive_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_we_n) |-> mem_dq_oe ##1 !mem_dq_oe);

    // R6
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R8
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (mem_cs_n && !mem_dq_oe));

    // R9
    addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_cs_n && $past(!mem_cs_n)) |-> $stable(mem_addr));
endmodule

bind asram_ctrl asram_ctrl_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .done      (done),
    .busy      (busy),
    .mem_cs_n  (mem_cs_n),
    .mem_we_n  (mem_we_n),
    .mem_oe_n  (mem_oe_n),
    .mem_addr  (mem_addr),
    .mem_dq_oe (mem_dq_oe)
);

// File: tb/test_asram_ctrl.sv
module test_asram_ctrl;
    localparam int AW = 15;
    localparam int DW = 8;
    localparam int PER = 10;

    // Independent expected phase lengths at the default timing.
    function automatic int cyc(int t);
        int c;
        c = (t + PER - 1) / PER;
        return (c < 1) ? 1 : c;
    endfunction
    function automatic int mx(int a, int b);
        return (a > b) ? a : b;
    endfunction
    localparam int RD_C  = mx(mx(cyc(15), cyc(15)), mx(cyc(15), cyc(8)));
    localparam int AS_C  = cyc(0);
    localparam int WP_C  = mx(mx(cyc(12), cyc(8) + 1), mx(cyc(12) - AS_C, 1));
    localparam int WR_C  = cyc(0);
    localparam int OHZ_C = cyc(8);
    localparam int WLAT  = AS_C + WP_C + WR_C;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req = 1'b0, req_we = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_wdata = '0;
    logic done, busy;
    logic [DW-1:0] rdata;
    logic mem_cs_n, mem_we_n, mem_oe_n, mem_dq_oe;
    logic [AW-1:0] mem_addr;
    logic [DW-1:0] mem_dq_out;
    logic [DW-1:0] mem_dq_in = '0;

    int checks = 0;
    int fails = 0;
    bit finished = 0;

    always #(PER/2) clk = ~clk;

    asram_ctrl i_asram_ctrl (
        .clk(clk), .rst_n(rst_n), .req(req), .req_we(req_we),
        .req_addr(req_addr), .req_wdata(req_wdata), .done(done), .busy(busy),
        .rdata(rdata), .mem_cs_n(mem_cs_n), .mem_we_n(mem_we_n),
        .mem_oe_n(mem_oe_n), .mem_addr(mem_addr), .mem_dq_out(mem_dq_out),
        .mem_dq_in(mem_dq_in), .mem_dq_oe(mem_dq_oe)
    );

    logic [DW-1:0] store [int];
    logic [DW-1:0] expmem [int];

    task automatic chk(bit ok, string tag, int act, int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic logic [DW-1:0] exp_get(int a);
        return expmem.exists(a) ? expmem[a] : '0;
    endfunction

    // Memory model and bus monitor, evaluated at falling edges.
    logic prev_we = 1'b1;
    logic rel_due = 1'b0;
    logic prev_cs = 1'b1;
    logic [AW-1:0] held_addr = '0;
    int low_cnt = 0;
    always @(negedge clk) begin
        if (!rst_n) begin
            prev_we = 1'b1; rel_due = 1'b0; prev_cs = 1'b1; low_cnt = 0;
        end else begin
            if (rel_due) begin
                chk(mem_dq_oe == 1'b0, "R5 release", int'(mem_dq_oe), 0);
                rel_due = 1'b0;
            end
            if (mem_dq_oe && !mem_cs_n && !mem_oe_n)
                chk(1'b0, "R5 contention", 1, 0);
            if (!mem_cs_n && !prev_cs && mem_addr != held_addr)
                chk(1'b0, "R9 addr hold", int'(mem_addr), int'(held_addr));
            if (!mem_we_n) begin
                low_cnt++;
                if (low_cnt == 1)
                    chk(mem_dq_oe == 1'b0, "R5 drive after strobe", int'(mem_dq_oe), 0);
                if (mem_cs_n || !mem_oe_n)
                    chk(1'b0, "R4 strobe overlap", {mem_cs_n, mem_oe_n}, 1);
            end else if (!prev_we) begin
                chk(low_cnt == WP_C, "R3 strobe width", low_cnt, WP_C);
                chk(mem_dq_oe == 1'b1, "R5 held at strobe rise", int'(mem_dq_oe), 1);
                if (!mem_cs_n) store[int'(mem_addr)] = mem_dq_out;
                low_cnt = 0;
                rel_due = 1'b1;
            end
            prev_we = mem_we_n;
            if (mem_cs_n == 1'b0 && prev_cs == 1'b1) held_addr = mem_addr;
            prev_cs = mem_cs_n;
            if (!mem_cs_n && !mem_oe_n && mem_we_n)
                mem_dq_in = store.exists(int'(mem_addr)) ? store[int'(mem_addr)] : '0;
            else
                mem_dq_in = '0;
        end
    end

    // One access; optionally poke a request while busy (R7).
    task automatic do_op(bit we, logic [AW-1:0] a, logic [DW-1:0] d, bit poke);
        int cnt;
        int t;
        bit busy_at_done;
        while (busy) @(negedge clk);
        req = 1'b1; req_we = we; req_addr = a; req_wdata = d;
        @(negedge clk);
        req = 1'b0;
        cnt = 1;
        while (!done && cnt < 40) begin
            if (poke && cnt == 2) begin
                req = 1'b1; req_we = 1'b1; req_addr = 15'h0100; req_wdata = 8'hFF;
            end else begin
                req = 1'b0;
            end
            @(negedge clk);
            cnt++;
        end
        req = 1'b0;
        if (we) begin
            chk(cnt == WLAT + 1, "R3 write latency", cnt, WLAT + 1);
            expmem[int'(a)] = d;
        end else begin
            chk(cnt == RD_C + 1, "R2 read latency", cnt, RD_C + 1);
            chk(rdata == exp_get(int'(a)), "R2 read data", int'(rdata), int'(exp_get(int'(a))));
        end
        busy_at_done = busy;
        @(negedge clk);
        chk(done == 1'b0, "R6 done width", int'(done), 0);
        if (we) begin
            chk(busy_at_done == 1'b0, "R8 write idle at done", int'(busy_at_done), 0);
        end else begin
            t = 1;
            while (busy && t < 20) begin
                @(negedge clk);
                t++;
            end
            chk(t == OHZ_C, "R8 read turnaround", t, OHZ_C);
            chk(mem_cs_n && !mem_dq_oe, "R8 quiet bus", {mem_cs_n, mem_dq_oe}, 2);
        end
    endtask

    initial begin
        int ndone;
        void'($urandom(32'h5EED));
        repeat (3) @(negedge clk);
        chk(mem_cs_n && mem_we_n && mem_oe_n, "R1 strobes idle", {mem_cs_n, mem_we_n, mem_oe_n}, 7);
        chk(!mem_dq_oe && !done && !busy, "R1 outputs low", {mem_dq_oe, done, busy}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(mem_cs_n && !busy && !done, "R1 after release", {mem_cs_n, busy, done}, 4);

        // Directed corners: boundary addresses and data.
        do_op(1'b1, 15'h0000, 8'h00, 1'b0);
        do_op(1'b1, 15'h7FFF, 8'hFF, 1'b0);
        do_op(1'b0, 15'h7FFF, 8'h00, 1'b0);
        do_op(1'b0, 15'h0000, 8'h00, 1'b0);
        do_op(1'b0, 15'h1234, 8'h00, 1'b0);
        // Write then read back immediately at the same address.
        do_op(1'b1, 15'h0100, 8'h5A, 1'b0);
        do_op(1'b0, 15'h0100, 8'h00, 1'b0);
        // R7: a request poked during a write must be dropped.
        do_op(1'b1, 15'h0200, 8'hC3, 1'b1);
        ndone = 0;
        repeat (8) begin
            @(negedge clk);
            if (done) ndone++;
        end
        chk(ndone == 0, "R7 no extra done", ndone, 0);
        do_op(1'b0, 15'h0100, 8'h00, 1'b0);
        chk(rdata == 8'h5A, "R7 memory unchanged", int'(rdata), 8'h5A);
        // R7: a poke during a read is also dropped.
        do_op(1'b0, 15'h0200, 8'h00, 1'b1);
        do_op(1'b0, 15'h0100, 8'h00, 1'b0);
        chk(rdata == 8'h5A, "R7 unchanged after read poke", int'(rdata), 8'h5A);

        // Random mix over a small address pool plus the full range.
        for (int i = 0; i < 300; i++) begin
            logic [AW-1:0] a;
            bit w;
            w = ($urandom % 2) == 1;
            if (($urandom % 4) == 0) a = AW'($urandom);
            else a = AW'($urandom % 32);
            do_op(w, a, DW'($urandom), ($urandom % 8) == 0);
        end
        if (!finished) begin
            finished = 1;
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end
endmodule